// File: doc/BRIEF.md
# Approximate restoring array divider

This block divides a 16-bit unsigned dividend by an 8-bit unsigned divisor in a single combinational array of restoring subtract cells. It returns an 8-bit quotient, an 8-bit remainder and an overflow flag. Each of the eight rows trial-subtracts the divisor from a 9-bit window: the partial remainder with the next dividend bit appended. From that result the row takes one quotient bit and either keeps the difference or restores the window.

Accuracy can be traded for logic depth at compile time. Parameter `P` replaces a triangle of cells at the least-significant corner of the array with reduced-logic cells, which shortens the borrow ripple. `CELL_TYPE` picks one of four simplified cell truth tables. With `P = 0` the array is an exact restoring divider.

Operands enter and results leave on valid/ready streams. With `REG_OUT = 1` a single output register sits between them. A result stays on the outputs until it is taken, and new operands are refused while a result is held and not taken. With `REG_OUT = 0` the block is a pure combinational pass-through.

Top module: `approx_restoring_div`

## Requirements
- R1: With P = 0 and a dividend whose upper byte is below the divisor, out_quot equals the integer quotient and out_rem equals the remainder of in_num / in_den.
- R2: out_ovf is 1 exactly when in_num[15:8] >= in_den. This includes every input with in_den = 0. Quotient and remainder are unspecified when out_ovf is 1.
- R3: Rows are numbered 0 (uses in_num[7]) to 7 (uses in_num[0]) and columns 0 (LSB) to 7. The cell at row r, column j is approximate iff j + (7 - r) < P. The ninth, guard column of every row stays exact. For P <= 8 this gives P(P+1)/2 approximate cells. For larger P (up to 14) the triangle is clipped at the array edge.
- R4: CELL_TYPE 0 cell: borrow-out = !a & b (borrow-in ignored), difference = a ^ b ^ bin, exact restore mux.
- R5: CELL_TYPE 1 cell: borrow-out = !a & (b | bin), difference = a ^ (b | bin), exact restore mux.
- R6: CELL_TYPE 2 merged cell: borrow-out = !a & b, output bit = a ^ (q & (b ^ bin)).
- R7: CELL_TYPE 3 merged cell: borrow-out = !a & (b | bin), output bit = a ^ (q & b).
- R8: A row's quotient bit is the inverse of the borrow out of its guard column. An exact cell passes its minuend bit when that quotient bit is 0 and its difference when it is 1.
- R9: With REG_OUT = 1, in_ready = !out_valid | out_ready. A transfer happens on a clock edge with in_valid & in_ready, and the result appears on the next cycle. While out_valid & !out_ready, all outputs hold.
- R10: With REG_OUT = 1, reset (rst_n low) clears out_valid and leaves in_ready high.
- R11: With REG_OUT = 0, out_valid = in_valid, in_ready = out_ready, and results follow the operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Operands can be taken |
| in_num | input | 16 | Dividend |
| in_den | input | 8 | Divisor |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_quot | output | 8 | Quotient |
| out_rem | output | 8 | Remainder |
| out_ovf | output | 1 | Quotient does not fit in 8 bits |

## Verification
The interesting coincidence is a held result under back-pressure in the same cycle as a new operand pair offered at the input. The bench stalls out_ready while the next pair is already valid. It then requires in_ready low, the old quotient, remainder and flag unchanged, and the new pair taken only on the edge where out_ready returns. The second overlap is the overflow flag alongside an approximate quotient: overflowing vectors are mixed into the random stream for every cell type, and only the flag is judged on them, while the other vectors are compared bit for bit with a bench model of the masked array.

// File: rtl/adiv_pkg.sv
package adiv_pkg;

  typedef enum int {
    CK_FAST_BORROW = 0,
    CK_OR_SUB      = 1,
    CK_MERGE_XOR   = 2,
    CK_MERGE_OR    = 3
  } cell_kind_e;

  // Triangle at the LSB corner of the last rows.
  function automatic bit cell_is_apx(int row, int col, int nrows, int p);
    return (col + (nrows - 1 - row)) < p;
  endfunction

endpackage

// File: rtl/adiv_cell.sv
module adiv_cell #(
  parameter bit APX  = 1'b0,
  parameter int KIND = 0
) (
  input  logic a,
  input  logic b,
  input  logic bin,
  input  logic q,
  output logic bout,
  output logic r
);
  import adiv_pkg::*;

  generate
    if (!APX) begin : g_exact
      logic dif;
      assign dif  = a ^ b ^ bin;
      assign bout = (~a & b) | (~a & bin) | (b & bin);
      assign r    = q ? dif : a;
    end else if (KIND == int'(CK_FAST_BORROW)) begin : g_k0
      logic dif;
      assign dif  = a ^ b ^ bin;
      assign bout = ~a & b;
      assign r    = q ? dif : a;
    end else if (KIND == int'(CK_OR_SUB)) begin : g_k1
      logic dif;
      assign dif  = a ^ (b | bin);
      assign bout = ~a & (b | bin);
      assign r    = q ? dif : a;
    end else if (KIND == int'(CK_MERGE_XOR)) begin : g_k2
      assign bout = ~a & b;
      assign r    = a ^ (q & (b ^ bin));
    end else begin : g_k3
      assign bout = ~a & (b | bin);
      assign r    = a ^ (q & b);
    end
  endgenerate

endmodule

// File: rtl/adiv_row.sv
module adiv_row #(
  parameter int W     = 8,
  parameter int ROW   = 0,
  parameter int NROWS = 8,
  parameter int P     = 0,
  parameter int KIND  = 0
) (
  input  logic [W:0]   x,
  input  logic [W-1:0] d,
  output logic [W-1:0] r,
  output logic         q
);
  import adiv_pkg::*;

  logic [W:0] bw;
  assign bw[0] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_col
    adiv_cell #(
      .APX (cell_is_apx(ROW, j, NROWS, P)),
      .KIND(KIND)
    ) u_cell (
      .a   (x[j]),
      .b   (d[j]),
      .bin (bw[j]),
      .q   (q),
      .bout(bw[j+1]),
      .r   (r[j])
    );
  end

  // Guard column subtracts zero; no borrow out means window >= divisor.
  assign q = x[W] | ~bw[W];

endmodule

// File: rtl/adiv_array.sv
module adiv_array #(
  parameter int W    = 8,
  parameter int P    = 0,
  parameter int KIND = 0
) (
  input  logic [2*W-1:0] num,
  input  logic [W-1:0]   den,
  output logic [W-1:0]   quot,
  output logic [W-1:0]   rem
);
  logic [W-1:0] part [W+1];

  assign part[0] = num[2*W-1:W];

  for (genvar k = 0; k < W; k++) begin : g_row
    adiv_row #(
      .W    (W),
      .ROW  (k),
      .NROWS(W),
      .P    (P),
      .KIND (KIND)
    ) u_row (
      .x({part[k], num[W-1-k]}),
      .d(den),
      .r(part[k+1]),
      .q(quot[W-1-k])
    );
  end

  assign rem = part[W];

endmodule

// File: rtl/approx_restoring_div.sv
module approx_restoring_div #(
  parameter int DEN_W     = 8,
  parameter int P         = 0,
  parameter int CELL_TYPE = 0,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*DEN_W-1:0]   in_num,
  input  logic [DEN_W-1:0]     in_den,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DEN_W-1:0]     out_quot,
  output logic [DEN_W-1:0]     out_rem,
  output logic                 out_ovf
);
  localparam int NUM_W = 2 * DEN_W;

  logic [DEN_W-1:0] c_quot, c_rem;
  logic             c_ovf;

  adiv_array #(.W(DEN_W), .P(P), .KIND(CELL_TYPE)) u_array (
    .num (in_num),
    .den (in_den),
    .quot(c_quot),
    .rem (c_rem)
  );

  assign c_ovf = in_num[NUM_W-1:DEN_W] >= in_den;

  generate
    if (REG_OUT) begin : g_reg
      logic             v_q;
      logic [DEN_W-1:0] q_q, r_q;
      logic             o_q;
      assign in_ready = ~v_q | out_ready;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
        end else if (in_ready) begin
          v_q <= in_valid;
        end
      end
      always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
          q_q <= c_quot;
          r_q <= c_rem;
          o_q <= c_ovf;
        end
      end
      assign out_valid = v_q;
      assign out_quot  = q_q;
      assign out_rem   = r_q;
      assign out_ovf   = o_q;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_quot  = c_quot;
      assign out_rem   = c_rem;
      assign out_ovf   = c_ovf;
    end
  endgenerate

endmodule

// File: rtl/adiv_chk.sv
module adiv_chk #(
  parameter int W       = 8,
  parameter int P       = 0,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2*W-1:0] in_num,
  input logic [W-1:0]   in_den,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W-1:0]   out_quot,
  input logic [W-1:0]   out_rem,
  input logic           out_ovf
);
  logic [2*W-1:0] k_num;
  logic [W-1:0]   k_den;

  generate
    if (REG_OUT) begin : g_seq
      always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
          k_num <= in_num;
          k_den <= in_den;
        end
      end

      // R9
      hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_quot) && $stable(out_rem) && $stable(out_ovf)));

      // R9
      ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

      // R10
      empty_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);
    end else begin : g_pass
      assign k_num = in_num;
      assign k_den = in_den;

      // R11
      pass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);
    end

    if (P == 0) begin : g_exact
      logic [2*W:0] recon;
      assign recon = (2*W+1)'(out_quot) * (2*W+1)'(k_den) + (2*W+1)'(out_rem);

      // R1
      exact_recon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ovf) |-> (recon == (2*W+1)'(k_num)));

      // R1
      rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ovf) |-> (out_rem < k_den));
    end
  endgenerate

  // R2
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ovf == (k_num[2*W-1:W] >= k_den)));

endmodule

bind approx_restoring_div adiv_chk #(.W(DEN_W), .P(P), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_num   (in_num),
  .in_den   (in_den),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_quot (out_quot),
  .out_rem  (out_rem),
  .out_ovf  (out_ovf)
);

// File: tb/tb_approx_restoring_div.sv
`timescale 1ns/1ps
module tb_approx_restoring_div;

  localparam int PA = 5;   // approximation factor for the four variant instances
  localparam int PC = 11;  // clipped triangle, combinational instance
  localparam int KC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [15:0] in_num = '0;
  logic [7:0]  in_den = 8'd1;

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // exact registered instance
  logic d_ir, d_ov, d_of;
  logic [7:0] d_q, d_r;
  approx_restoring_div dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(d_ir),
    .in_num(in_num), .in_den(in_den), .out_valid(d_ov), .out_ready(out_ready),
    .out_quot(d_q), .out_rem(d_r), .out_ovf(d_of));

  // one registered instance per cell type
  logic       a_ir [4];
  logic       a_ov [4];
  logic       a_of [4];
  logic [7:0] a_q  [4];
  logic [7:0] a_r  [4];
  for (genvar k = 0; k < 4; k++) begin : g_apx
    approx_restoring_div #(.P(PA), .CELL_TYPE(k), .REG_OUT(1'b1)) u_apx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_ir[k]),
      .in_num(in_num), .in_den(in_den), .out_valid(a_ov[k]), .out_ready(out_ready),
      .out_quot(a_q[k]), .out_rem(a_r[k]), .out_ovf(a_of[k]));
  end

  // combinational instance with a clipped triangle
  logic c_ir, c_ov, c_of;
  logic [7:0] c_q, c_r;
  approx_restoring_div #(.P(PC), .CELL_TYPE(KC), .REG_OUT(1'b0)) u_cmb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_ir),
    .in_num(in_num), .in_den(in_den), .out_valid(c_ov), .out_ready(out_ready),
    .out_quot(c_q), .out_rem(c_r), .out_ovf(c_of));

  // Bench model of the masked array, written from R3..R8: returns {quot, rem}.
  function automatic logic [15:0] model(input logic [15:0] num, input logic [7:0] den,
                                        input int p, input int kind);
    logic [7:0] part;
    logic [7:0] quot;
    part = num[15:8];
    quot = '0;
    for (int row = 0; row < 8; row++) begin
      logic [8:0] x;
      logic [8:0] bw;
      logic [7:0] nxt;
      logic q;
      x = {part, num[7-row]};
      bw[0] = 1'b0;
      for (int j = 0; j < 8; j++) begin
        logic a, b, c;
        a = x[j]; b = den[j]; c = bw[j];
        if ((j + (7 - row)) < p) begin
          if (kind == 0 || kind == 2) bw[j+1] = ~a & b;
          else                        bw[j+1] = ~a & (b | c);
        end else begin
          bw[j+1] = (~a & b) | (~a & c) | (b & c);
        end
      end
      q = ~(~x[8] & bw[8]);
      for (int j = 0; j < 8; j++) begin
        logic a, b, c;
        a = x[j]; b = den[j]; c = bw[j];
        if ((j + (7 - row)) < p) begin
          case (kind)
            0: nxt[j] = q ? (a ^ b ^ c) : a;
            1: nxt[j] = q ? (a ^ (b | c)) : a;
            2: nxt[j] = a ^ (q & (b ^ c));
            default: nxt[j] = a ^ (q & b);
          endcase
        end else begin
          nxt[j] = q ? (a ^ b ^ c) : a;
        end
      end
      quot[7-row] = q;
      part = nxt;
    end
    return {quot, part};
  endfunction

  function automatic string kind_tag(input int k);
    case (k)
      0: return "R3 R4 R8";
      1: return "R3 R5 R8";
      2: return "R3 R6";
      default: return "R3 R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offer one operand pair at a negedge, check the combinational instance
  // before the edge and the registered ones after it.
  task automatic run_vec(input logic [15:0] num, input logic [7:0] den);
    logic ovf;
    logic [15:0] e;
    ovf = num[15:8] >= den;
    @(negedge clk);
    in_num = num; in_den = den; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk("R11 valid", {16'd0, c_ov}, 17'd1);
    chk("R2 comb", {16'd0, c_of}, {16'd0, ovf});
    if (!ovf) begin
      e = model(num, den, PC, KC);
      chk("R3 R7 R11 clipped", {1'b0, c_q, c_r}, {1'b0, e});
    end
    @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid", {16'd0, d_ov}, 17'd1);
    chk("R2 exact", {16'd0, d_of}, {16'd0, ovf});
    if (!ovf) begin
      logic [7:0] eq, er;
      eq = 8'(num / 16'(den));
      er = 8'(num % 16'(den));
      chk("R1", {1'b0, d_q, d_r}, {1'b0, eq, er});
    end
    for (int k = 0; k < 4; k++) begin
      chk("R2 variant", {16'd0, a_of[k]}, {16'd0, ovf});
      if (!ovf) begin
        e = model(num, den, PA, k);
        chk(kind_tag(k), {1'b0, a_q[k], a_r[k]}, {1'b0, e});
      end
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 valid in reset", {16'd0, d_ov}, 17'd0);
    chk("R10 ready in reset", {16'd0, d_ir}, 17'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", {16'd0, d_ov}, 17'd0);

    // directed corners
    run_vec(16'h00FF, 8'd1);
    run_vec(16'hFEFF, 8'd255);
    run_vec(16'h0000, 8'd7);
    run_vec(16'h7FFF, 8'd128);
    run_vec(16'h00FF, 8'd255);
    run_vec(16'h0C35, 8'd13);
    run_vec(16'h1234, 8'd0);    // R2: zero divisor
    run_vec(16'h4000, 8'd64);   // R2: upper byte equals divisor
    run_vec(16'hFFFF, 8'd200);

    // back-pressure with a new pair waiting (R9)
    @(negedge clk);
    in_num = 16'h2710; in_den = 8'd100; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_num = 16'h0105; in_den = 8'd3; out_ready = 1'b0;
    #1;
    chk("R9 in_ready stalled", {16'd0, d_ir}, 17'd0);
    chk("R11 in_ready follows", {16'd0, c_ir}, 17'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 held result", {d_of, d_q, d_r}, {1'b0, 8'd100, 8'd0});
    chk("R9 held valid", {16'd0, d_ov}, 17'd1);
    out_ready = 1'b1;
    #1;
    chk("R9 in_ready released", {16'd0, d_ir}, 17'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 next result", {d_of, d_q, d_r}, {1'b0, 8'd87, 8'd0});
    in_valid = 1'b0;
    #1;
    chk("R11 valid low", {16'd0, c_ov}, 17'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", {16'd0, d_ov}, 17'd0);

    // constrained random, mostly in range, some overflowing
    for (int i = 0; i < 400; i++) begin
      logic [7:0] den;
      logic [7:0] hi;
      den = 8'($urandom_range(1, 255));
      if ($urandom_range(0, 9) == 0) begin
        hi = 8'($urandom_range(int'(den), 255));
        if ($urandom_range(0, 3) == 0) den = 8'd0;
      end else begin
        hi = 8'($urandom_range(0, int'(den) - 1));
      end
      run_vec({hi, 8'($urandom_range(0, 255))}, den);
    end

    @(negedge clk);
    in_valid = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule